// File: doc/BRIEF.md
# Two-Die Interleaved Program Scheduler

This block sits between a host that produces page-program requests and a lower-level bus sequencer that drives the command, address and data cycles of a shared NAND bus. Two dies share the bus. Each request names its target die (0 or 1) and a page. The scheduler keeps a small request queue and starts a program on one die while the other die is still busy. This keeps the bus loaded during the long internal program time.

The scheduler tracks each die separately. A die may take a new program only after its own status byte, read through that die's dedicated status command, has shown it ready. After each program the scheduler waits a programmable settle gap and then polls that die. When both dies need polling, the polls alternate between them. The poll that turns a busy die ready produces a completion carrying the die's pass/fail bit. A host request for the ordinary combined status read is forwarded only when no program is in flight. Otherwise it is refused, because that command must never appear on the bus while dies work interleaved.

Top module: `ilv_prog_sched`

## Requirements
- R1: The request queue holds up to 4 entries. `req_ready` is low exactly when 4 entries are held, and a request offered while `req_ready` is low is not taken.
- R2: A program is issued on the sequencer as command 80h. It goes to a die only if that die has no program in flight and a status poll of that die has reported bit 6 = 1 since that die's last program.
- R3: Among queued requests whose die is eligible under R2, the oldest is dispatched first. A younger request for a ready die may pass an older one for a busy die, and order within each die is kept.
- R4: Die 0 is polled with command F1h and die 1 with F2h. After the sequencer reports a program done (`seq_done`), that die is not polled for at least `settle_gap` cycles.
- R5: When both dies have a program in flight and both may be polled, successive polls alternate between the dies.
- R6: A poll whose byte has bit 6 = 1, for a die with a program in flight, gives a one-cycle `cpl_valid` with `cpl_die` set to that die and `cpl_fail` equal to status bit 0, on the cycle after `seq_done`. A poll with bit 6 = 0 gives no completion and leaves the die busy.
- R7: `die_busy[d]` is high from the program's `seq_done` until the completing poll. `shared_rdy` is low while either die is busy.
- R8: A `gstat_req` is sent as command 70h only while no die has a program in flight, and it returns the byte on `gstat_byte` with `gstat_done`. While a program is in flight the request is answered with `gstat_rej`, and 70h never appears on the sequencer.
- R9: After reset the queue is empty (`req_ready` high), `seq_valid`, `cpl_valid` and `die_busy` are low, `shared_rdy` is high, and the first operation issued is a poll of die 0 (F1h).
- R10: The sequencer carries one operation at a time. `seq_valid` and its command, die and page stay stable until `seq_ready`. `seq_valid` then drops, and no new operation starts before `seq_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| settle_gap | input | GAP_W | Cycles to wait after a program before polling that die |
| req_valid | input | 1 | Host offers a program request |
| req_die | input | 1 | Target die of the request |
| req_page | input | PAGE_W | Target page of the request |
| req_ready | output | 1 | Queue has room |
| seq_valid | output | 1 | Operation offered to the sequencer |
| seq_cmd | output | 8 | Operation command: 80h program, F1h/F2h die poll, 70h combined status |
| seq_die | output | 1 | Die addressed by the operation |
| seq_page | output | PAGE_W | Page of a program operation |
| seq_ready | input | 1 | Sequencer accepts the operation |
| seq_done | input | 1 | Sequencer finished the operation |
| seq_stat | input | 8 | Status byte returned with `seq_done` for status operations |
| cpl_valid | output | 1 | One-cycle program completion |
| cpl_die | output | 1 | Die that completed |
| cpl_fail | output | 1 | Pass/fail bit of the completed program |
| gstat_req | input | 1 | Host asks for a combined status read |
| gstat_done | output | 1 | Combined status read finished |
| gstat_rej | output | 1 | Combined status read refused (program in flight) |
| gstat_byte | output | 8 | Byte returned by the combined status read |
| die_busy | output | 2 | Per-die program-in-flight flags |
| shared_rdy | output | 1 | High when neither die is busy |

## Verification
Two events can land on the same clock edge: a new request is pushed into the queue while a dispatch removes an entry from the middle of it. The bench provokes this with random host pushes at random idle gaps while both dies finish programs at random times, so pushes keep meeting dispatches that skip over entries for a busy die. It judges the result with its own queue model. Every program that reaches the sequencer must match the oldest model entry whose die has been confirmed ready. A directed phase fills the queue behind two long programs, so that dispatching past older entries also happens at full depth.

// File: rtl/ilv_prog_sched.sv
module ilv_prog_sched #(
  parameter int DEPTH  = 4,
  parameter int PAGE_W = 16,
  parameter int GAP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GAP_W-1:0]  settle_gap,
  input  logic              req_valid,
  input  logic              req_die,
  input  logic [PAGE_W-1:0] req_page,
  output logic              req_ready,
  output logic              seq_valid,
  output logic [7:0]        seq_cmd,
  output logic              seq_die,
  output logic [PAGE_W-1:0] seq_page,
  input  logic              seq_ready,
  input  logic              seq_done,
  input  logic [7:0]        seq_stat,
  output logic              cpl_valid,
  output logic              cpl_die,
  output logic              cpl_fail,
  input  logic              gstat_req,
  output logic              gstat_done,
  output logic              gstat_rej,
  output logic [7:0]        gstat_byte,
  output logic [1:0]        die_busy,
  output logic              shared_rdy
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [7:0] C_PROG = 8'h80;
  localparam logic [7:0] C_ST0  = 8'hF1;
  localparam logic [7:0] C_ST1  = 8'hF2;
  localparam logic [7:0] C_STG  = 8'h70;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  typedef enum logic [1:0] {OP_PROG, OP_POLL, OP_GST} op_t;

  st_t st;
  op_t op;
  logic [CW-1:0]     cnt;
  logic              q_die  [DEPTH];
  logic [PAGE_W-1:0] q_page [DEPTH];
  logic [1:0]        inflight, seen, want_poll;
  logic [GAP_W-1:0]  gap_cnt [2];
  logic              poll_ptr, poll_die, gst_pend;
  logic              hit, push, do_prog;
  logic [IW-1:0]     hit_idx, wr_idx;

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (CW'(i) < cnt && seen[q_die[i]]) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
  end

  assign want_poll  = ~seen & {gap_cnt[1] == '0, gap_cnt[0] == '0};
  assign poll_die   = (&want_poll) ? poll_ptr : want_poll[1];
  assign req_ready  = cnt < CW'(DEPTH);
  assign push       = req_valid && req_ready;
  assign do_prog    = (st == S_IDLE) && !gst_pend && hit;
  assign wr_idx     = IW'(cnt - CW'(do_prog));
  assign die_busy   = inflight;
  assign shared_rdy = ~|inflight;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        q_die[i]  <= 1'b0;
        q_page[i] <= '0;
      end
    end else begin
      if (do_prog)
        for (int i = 0; i < DEPTH - 1; i++)
          if (IW'(i) >= hit_idx) begin
            q_die[i]  <= q_die[i+1];
            q_page[i] <= q_page[i+1];
          end
      if (push) begin
        q_die[wr_idx]  <= req_die;
        q_page[wr_idx] <= req_page;
      end
      cnt <= cnt + CW'(push) - CW'(do_prog);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      op <= OP_POLL;
      seq_valid <= 1'b0;
      seq_cmd <= '0;
      seq_die <= 1'b0;
      seq_page <= '0;
      inflight <= '0;
      seen <= '0;
      gap_cnt[0] <= '0;
      gap_cnt[1] <= '0;
      poll_ptr <= 1'b0;
      gst_pend <= 1'b0;
      cpl_valid <= 1'b0;
      cpl_die <= 1'b0;
      cpl_fail <= 1'b0;
      gstat_done <= 1'b0;
      gstat_rej <= 1'b0;
      gstat_byte <= '0;
    end else begin
      cpl_valid  <= 1'b0;
      gstat_done <= 1'b0;
      gstat_rej  <= 1'b0;
      for (int d = 0; d < 2; d++)
        if (gap_cnt[d] != '0) gap_cnt[d] <= gap_cnt[d] - 1'b1;
      if (gstat_req) gst_pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (gst_pend) begin
            gst_pend <= 1'b0;
            if (|inflight) gstat_rej <= 1'b1;
            else begin
              op <= OP_GST; seq_cmd <= C_STG; seq_die <= 1'b0;
              seq_valid <= 1'b1; st <= S_REQ;
            end
          end else if (hit) begin
            op <= OP_PROG; seq_cmd <= C_PROG;
            seq_die <= q_die[hit_idx]; seq_page <= q_page[hit_idx];
            seq_valid <= 1'b1; st <= S_REQ;
          end else if (|want_poll) begin
            op <= OP_POLL; seq_cmd <= poll_die ? C_ST1 : C_ST0;
            seq_die <= poll_die; poll_ptr <= ~poll_die;
            seq_valid <= 1'b1; st <= S_REQ;
          end
        end
        S_REQ: if (seq_ready) begin
          seq_valid <= 1'b0;
          st <= S_WAIT;
        end
        S_WAIT: if (seq_done) begin
          st <= S_IDLE;
          case (op)
            OP_PROG: begin
              inflight[seq_die] <= 1'b1;
              seen[seq_die] <= 1'b0;
              gap_cnt[seq_die] <= settle_gap;
            end
            OP_POLL: if (seq_stat[6]) begin
              seen[seq_die] <= 1'b1;
              if (inflight[seq_die]) begin
                inflight[seq_die] <= 1'b0;
                cpl_valid <= 1'b1;
                cpl_die <= seq_die;
                cpl_fail <= seq_stat[0];
              end
            end
            default: begin
              gstat_done <= 1'b1;
              gstat_byte <= seq_stat;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end

  // R1
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R2
  prog_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && seq_cmd == C_PROG |-> seen[seq_die] && !inflight[seq_die]);
  // R4
  poll_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && (seq_cmd == C_ST0 || seq_cmd == C_ST1) |-> seq_die == (seq_cmd == C_ST1) && gap_cnt[seq_die] == '0);
  // R6
  cpl_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> $past(st == S_WAIT && seq_done && op == OP_POLL && seq_stat[6]));
  // R8
  no_plain_stat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && seq_cmd == C_STG |-> inflight == 2'b00);
  // R10
  seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid && !seq_ready |=> seq_valid && $stable(seq_cmd) && $stable(seq_die) && $stable(seq_page));
endmodule

// File: tb/test_ilv_prog_sched.sv
module test_ilv_prog_sched;
  localparam int PW = 16;
  localparam int GW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [GW-1:0] settle_gap = '0;
  logic req_valid = 1'b0, req_die = 1'b0;
  logic [PW-1:0] req_page = '0;
  logic req_ready, seq_valid, seq_die, seq_ready, seq_done;
  logic [7:0] seq_cmd, seq_stat;
  logic [PW-1:0] seq_page;
  logic cpl_valid, cpl_die, cpl_fail, gstat_req, gstat_done, gstat_rej;
  logic [7:0] gstat_byte;
  logic [1:0] die_busy;
  logic shared_rdy;

  ilv_prog_sched #(.DEPTH(4), .PAGE_W(PW), .GAP_W(GW)) i_ilv_prog_sched (
    .clk, .rst_n, .settle_gap, .req_valid, .req_die, .req_page, .req_ready,
    .seq_valid, .seq_cmd, .seq_die, .seq_page, .seq_ready, .seq_done, .seq_stat,
    .cpl_valid, .cpl_die, .cpl_fail, .gstat_req, .gstat_done, .gstat_rej,
    .gstat_byte, .die_busy, .shared_rdy);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, n_push = 0, n_cpl = 0, n_gst = 0;
  int btime [2];
  bit bfail [2];
  bit long_busy = 1'b0;
  bit [1:0] m_inflight = '0, m_seen = '0;
  int done_cyc [2];
  bit qd [64];
  logic [PW-1:0] qp [64];
  int qn = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic int oldest_elig();
    for (int i = 0; i < qn; i++) if (m_seen[qd[i]]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] poll_cmd(input bit d);
    return d ? 8'hF2 : 8'hF1;
  endfunction

  function automatic logic [7:0] die_stat(input bit d);
    return (btime[d] > 0) ? 8'h80 : {7'b1100000, bfail[d]};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int d = 0; d < 2; d++) if (btime[d] > 0) btime[d] <= btime[d] - 1;
  end

  initial begin : seqm
    int opn, stall, first, k;
    logic [7:0] c, s;
    logic d, pd, pbusy;
    logic [PW-1:0] p;
    opn = 0; pbusy = 1'b0; pd = 1'b0;
    seq_ready = 1'b0; seq_done = 1'b0; seq_stat = '0;
    forever begin
      @(negedge clk);
      if (!(rst_n && seq_valid)) continue;
      first = cyc; c = seq_cmd; d = seq_die; p = seq_page;
      if (opn == 0) chk(c == 8'hF1, "R9 first op", c, 8'hF1);
      stall = $urandom_range(0, 2);
      repeat (stall) @(negedge clk);
      chk(seq_valid && seq_cmd == c && seq_die == d && seq_page == p, "R10 hold", seq_cmd, c);
      seq_ready = 1'b1;
      @(negedge clk);
      seq_ready = 1'b0;
      chk(!seq_valid, "R10 drop", seq_valid, 0);
      s = 8'h00;
      if (c == 8'h80) begin
        chk(m_seen[d] && !m_inflight[d], "R2 die ready", m_seen[d], 1);
        k = oldest_elig();
        chk(k >= 0 && qd[k] == d && qp[k] == p, "R3 order", p, (k >= 0) ? qp[k] : -1);
        if (k >= 0) begin
          for (int i = k; i < qn - 1; i++) begin qd[i] = qd[i+1]; qp[i] = qp[i+1]; end
          qn--;
        end
      end else if (c == 8'hF1 || c == 8'hF2) begin
        chk(c == poll_cmd(d), "R4 poll cmd", c, poll_cmd(d));
        if (m_inflight[d]) chk(first - done_cyc[d] >= int'(settle_gap), "R4 settle", first - done_cyc[d], settle_gap);
        if (pbusy && m_inflight == 2'b11 && settle_gap == 0) chk(d != pd, "R5 alternate", d, !pd);
        s = die_stat(d);
      end else if (c == 8'h70) begin
        chk(m_inflight == 2'b00, "R8 no 70h busy", m_inflight, 0);
        s = 8'hE5;
      end else chk(1'b0, "R10 bad cmd", c, 0);
      repeat ($urandom_range(0, 2)) @(negedge clk);
      seq_stat = s; seq_done = 1'b1;
      @(negedge clk);
      seq_done = 1'b0;
      pbusy = 1'b0;
      if (c == 8'h80) begin
        m_inflight[d] = 1'b1; m_seen[d] = 1'b0; done_cyc[d] = cyc;
        btime[d] = long_busy ? 400 : $urandom_range(4, 40);
        bfail[d] = 1'($urandom_range(0, 1));
        chk(die_busy == m_inflight && !shared_rdy, "R7 busy set", die_busy, m_inflight);
      end else if (c == 8'h70) begin
        chk(gstat_done && gstat_byte == 8'hE5, "R8 byte", gstat_byte, 8'hE5);
        n_gst++;
      end else begin
        if (s[6]) begin
          m_seen[d] = 1'b1;
          if (m_inflight[d]) begin
            chk(cpl_valid && cpl_die == d && cpl_fail == s[0], "R6 cpl", {cpl_valid, cpl_die, cpl_fail}, {1'b1, d, s[0]});
            m_inflight[d] = 1'b0;
            n_cpl++;
          end else chk(!cpl_valid, "R6 no cpl idle", cpl_valid, 0);
        end else begin
          chk(!cpl_valid, "R6 busy no cpl", cpl_valid, 0);
          pbusy = 1'b1; pd = d;
        end
        chk(die_busy == m_inflight && shared_rdy == (m_inflight == 0), "R7 flags", die_busy, m_inflight);
      end
      opn++;
    end
  end

  task automatic push(input bit d, input logic [PW-1:0] p);
    bit ok;
    req_valid = 1'b1; req_die = d; req_page = p;
    forever begin
      ok = req_ready;
      if (ok) begin qd[qn] = d; qp[qn] = p; qn++; n_push++; end
      @(negedge clk);
      if (ok) break;
    end
    req_valid = 1'b0;
  endtask

  task automatic gst_pulse();
    gstat_req = 1'b1;
    @(negedge clk);
    gstat_req = 1'b0;
  endtask

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++) begin
      repeat ($urandom_range(0, 3)) @(negedge clk);
      push(1'($urandom_range(0, 1)), PW'($urandom));
    end
    wait (n_cpl == n_push);
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=%0d", n_cpl, n_push);
    finish_run();
  end

  initial begin
    bit seen_rej;
    void'($urandom(32'd20240611));
    btime[0] = 0; btime[1] = 0; bfail[0] = 0; bfail[1] = 0;
    gstat_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !seq_valid && !cpl_valid && die_busy == 0 && shared_rdy, "R9 reset", {req_ready, seq_valid, die_busy}, 4'b1000);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    gst_pulse();
    wait (n_gst == 1);
    @(negedge clk);

    settle_gap = 0;
    rand_phase(30);
    settle_gap = GW'($urandom_range(3, 20));
    rand_phase(30);

    settle_gap = 2;
    long_busy = 1'b1;
    push(1'b0, 16'h0A00);
    push(1'b1, 16'h0B00);
    wait (m_inflight == 2'b11);
    @(negedge clk);
    gst_pulse();
    seen_rej = 1'b0;
    repeat (30) begin
      if (gstat_rej) seen_rej = 1'b1;
      @(negedge clk);
    end
    chk(seen_rej, "R8 reject", seen_rej, 1);
    long_busy = 1'b0;
    push(1'b1, 16'h1001);
    push(1'b0, 16'h1002);
    push(1'b1, 16'h1003);
    push(1'b0, 16'h1004);
    chk(!req_ready, "R1 full", req_ready, 0);
    req_valid = 1'b1; req_die = 1'b0; req_page = 16'hDEAD;
    repeat (5) begin
      chk(!req_ready, "R1 hold off", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait (n_cpl == n_push);
    repeat (5) @(negedge clk);
    chk(qn == 0 && die_busy == 0 && shared_rdy && req_ready, "R7 drained", qn, 0);
    finish_run();
  end
endmodule